// File: doc/BRIEF.md
# Five-Source Interrupt Collector

This block gathers event pulses from the timers, the time-of-day alarm, the serial shifter and an external flag pin into one sticky status register. Each source owns one status bit, and that bit stays set until the host reads the status. An enable mask chooses which sources may raise the interrupt request. The request line is active low. The host changes the mask through a write port: bit 7 of the written byte selects whether the 1 bits in the low bits set mask bits or clear them. Any mask bit whose data bit is 0 keeps its value.

A single read returns the whole status byte and clears the register. Bit 7 of that byte is a summary flag. It is set once an enabled source has fired, or once a mask write enables a source that is already pending. The summary bit holds the request line low until the next read. The flag pin passes through a synchronizer, and only its falling edge counts as an event. Pulses that arrive in the same cycle as a read go into the cleared register, so the next read reports them.

Top module: `irq_collect`

## Requirements
- R1: After synchronous reset, the status and the mask are zero, `irq_n` is 1 and `rd_data` is 0.
- R2: A one-cycle pulse on a source sets its status bit whatever the mask holds. The bits are: bit 0 timer A (`evt_pulse[0]`), bit 1 timer B (`evt_pulse[1]`), bit 2 alarm (`evt_pulse[2]`), bit 3 serial (`evt_pulse[3]`), bit 4 external flag.
- R3: A pulse on a source whose mask bit is 1 sets status bit 7 and drives `irq_n` low. Both take effect at the same clock edge that sets the source bit.
- R4: A pulse on a source whose mask bit is 0 leaves status bit 7 at 0 and `irq_n` at 1.
- R5: A mask write with `wr_data[7]`=1 sets each mask bit whose data bit in 4:0 is 1. All other mask bits keep their value.
- R6: A mask write with `wr_data[7]`=0 clears each mask bit whose data bit in 4:0 is 1. All other mask bits keep their value.
- R7: A mask write that enables a source whose status bit is already pending sets status bit 7 and drives `irq_n` low at the write's clock edge.
- R8: A cycle with `stat_rd`=1 loads `rd_data` with the status at that edge and clears every status bit. The status byte is {summary, 0, 0, sources[4:0]}. If no source pulses in that cycle, `irq_n` returns to 1.
- R9: A source pulse in the same cycle as a read is left out of that read's `rd_data` and appears in the next read. If its mask bit is 1, `irq_n` goes low again.
- R10: A falling edge on `flag_n` sets status bit 4 once, three clock edges after the change (two-stage synchronizer). A rising edge and a steady low level set nothing.
- R11: Once low, `irq_n` stays low until a read, even if the mask is cleared in the meantime.
- R12: Status bits 6 and 5 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT (4) | One-cycle event pulses: timer A, timer B, alarm, serial |
| flag_n | input | 1 | Asynchronous external flag pin; its falling edge is an event |
| mask_wr | input | 1 | Mask write strobe |
| wr_data | input | DATA_W (8) | Mask write data; bit 7 selects set (1) or clear (0) |
| stat_rd | input | 1 | Status read strobe; clears the status |
| rd_data | output | DATA_W (8) | Registered status snapshot of the last read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: four pulse sources, one flag pin, an 8-bit data path and a two-stage synchronizer. With these values every status position, including the zero-padding bits 6 and 5, can be checked against a fixed byte. The synchronizer delay is short enough that a flag edge shows up within a few cycles of waiting. Directed scenarios cover several situations:
- a read that coincides with a new pulse;
- a mask write that enables an already pending source;
- a mask cleared while the request is held low;
- a flag pin held low across a read, which must not count again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Status bit positions that the host software decodes
  localparam int SRC_TMR_A  = 0;
  localparam int SRC_TMR_B  = 1;
  localparam int SRC_ALARM  = 2;
  localparam int SRC_SERIAL = 3;

  typedef enum logic {MASK_CLEAR = 1'b0, MASK_SET = 1'b1} mask_op_e;
endpackage

// File: rtl/irqc_flag_sync.sv
module irqc_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], pin_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];

  // R10: a single falling edge yields a single event
  a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [DATA_W-1:0]  data,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nxt
);
  localparam int OP_BIT = DATA_W - 1;

  mask_op_e           op;
  logic [NUM_SRC-1:0] sel;

  assign op  = mask_op_e'(data[OP_BIT]);
  assign sel = data[NUM_SRC-1:0];

  always_comb begin
    mask_nxt = mask_q;
    if (wr) begin
      if (op == MASK_SET) mask_nxt = mask_q | sel;
      else                mask_nxt = mask_q & ~sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end

  // R5: selected bits become 1 on a set write
  a_r5_set_bits: assert property (@(posedge clk) disable iff (rst)
    (wr && data[OP_BIT]) |=> ((mask_q & $past(sel)) == $past(sel)));
  // R6: selected bits become 0 on a clear write
  a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (wr && !data[OP_BIT]) |=> ((mask_q & $past(sel)) == '0));
  // R5, R6: unselected bits and idle cycles leave the mask alone
  a_r5_untouched: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((mask_q & ~$past(sel)) == ($past(mask_q) & ~$past(sel))));
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mask_q));
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [NUM_SRC-1:0] set,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] mask_nxt,
  input  logic               mask_wr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_n
);
  localparam int SUM_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] pend_q, pend_keep, pend_nxt;
  logic               sum_q, sum_nxt;
  logic [DATA_W-1:0]  snap;

  // A read empties the register, but pulses of the same cycle land afterwards
  assign pend_keep = rd ? '0 : pend_q;
  assign pend_nxt  = pend_keep | set;

  always_comb begin
    sum_nxt = sum_q & ~rd;
    if (|(set & mask_q)) sum_nxt = 1'b1;
    if (mask_wr && |(pend_nxt & mask_nxt)) sum_nxt = 1'b1;
  end

  always_comb begin
    snap                = '0;
    snap[NUM_SRC-1:0]   = pend_q;
    snap[SUM_BIT]       = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      sum_q   <= 1'b0;
      irq_n   <= 1'b1;
      rd_data <= '0;
    end else begin
      pend_q <= pend_nxt;
      sum_q  <= sum_nxt;
      irq_n  <= ~sum_nxt;
      if (rd) rd_data <= snap;
    end
  end

  // R2: pending bits are sticky while no read occurs
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R3: an enabled pulse pulls the request low
  a_r3_enabled_fires: assert property (@(posedge clk) disable iff (rst)
    (|(set & mask_q)) |=> !irq_n);
  // R8: a quiet read clears everything and releases the request
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd && set == '0) |=> (pend_q == '0 && irq_n));
  // R9: a pulse coincident with a read survives it
  a_r9_keep_pulse: assert property (@(posedge clk) disable iff (rst)
    (rd && set != '0) |=> (pend_q == $past(set)));
  // R11: the request holds until a read
  a_r11_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !rd) |=> !irq_n);
endmodule

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int NUM_EVT     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               flag_n,
  input  logic               mask_wr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               stat_rd,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_n
);
  localparam int NUM_SRC  = NUM_EVT + 1;
  localparam int FLAG_BIT = NUM_EVT;

  logic               flag_fall;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] mask_q, mask_nxt;

  irqc_flag_sync #(.STAGES(SYNC_STAGES)) u_flag (
    .clk   (clk),
    .rst   (rst),
    .pin_n (flag_n),
    .fall  (flag_fall)
  );

  always_comb begin
    src_set                 = '0;
    src_set[NUM_EVT-1:0]    = evt_pulse;
    src_set[FLAG_BIT]       = flag_fall;
  end

  irqc_mask #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .wr       (mask_wr),
    .data     (wr_data),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  irqc_status #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .rd       (stat_rd),
    .set      (src_set),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt),
    .mask_wr  (mask_wr),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
  );

  // R12: padding bits between the sources and the summary stay zero
  a_r12_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-2:NUM_SRC] == '0);
endmodule

// File: tb/test_irq_collect.sv
module test_irq_collect;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] evt_pulse;
  logic       flag_n;
  logic       mask_wr;
  logic [7:0] wr_data;
  logic       stat_rd;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_collect i_irq_collect (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .flag_n(flag_n),
    .mask_wr(mask_wr), .wr_data(wr_data), .stat_rd(stat_rd),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk) evt_pulse = m;
    @(negedge clk) evt_pulse = '0;
  endtask

  task automatic wmask(input logic [7:0] d);
    @(negedge clk) begin mask_wr = 1'b1; wr_data = d; end
    @(negedge clk) mask_wr = 1'b0;
  endtask

  task automatic rdstat(output logic [7:0] v);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rd_data after reset", rd_data, 8'h00);
    chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rdstat(v);
    chk("R1 status after reset", v, 8'h00);
  endtask

  task automatic t_masked_sources;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      chk("R4 masked pulse keeps irq_n high", {7'b0, irq_n}, 8'h01);
      rdstat(v);
      chk("R2 source bit position", v, 8'(1 << i));
    end
  endtask

  task automatic t_enable_set;
    logic [7:0] v;
    wmask(8'h81);
    pulse(4'b0001);
    chk("R3 enabled pulse asserts irq_n", {7'b0, irq_n}, 8'h00);
    rdstat(v);
    chk("R3 summary set", v, 8'h81);
    chk("R8 read releases irq_n", {7'b0, irq_n}, 8'h01);
    wmask(8'h82);
    pulse(4'b0001);
    rdstat(v);
    chk("R5 set write keeps other bits", v, 8'h81);
    pulse(4'b0010);
    rdstat(v);
    chk("R5 new bit enabled", v, 8'h82);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wmask(8'h01);
    pulse(4'b0001);
    chk("R6 cleared bit no irq", {7'b0, irq_n}, 8'h01);
    rdstat(v);
    chk("R6 cleared bit status", v, 8'h01);
    pulse(4'b0010);
    rdstat(v);
    chk("R6 other bit still enabled", v, 8'h82);
  endtask

  task automatic t_late_enable;
    logic [7:0] v;
    wmask(8'h7F);
    pulse(4'b0100);
    chk("R7 pending while masked", {7'b0, irq_n}, 8'h01);
    wmask(8'h84);
    chk("R7 enable of pending asserts irq_n", {7'b0, irq_n}, 8'h00);
    rdstat(v);
    chk("R7 summary after enable", v, 8'h84);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    pulse(4'b0100);
    wmask(8'h04);
    repeat (5) @(negedge clk);
    chk("R11 irq_n held after mask clear", {7'b0, irq_n}, 8'h00);
    rdstat(v);
    chk("R11 status read", v, 8'h84);
    chk("R11 released by read", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_coincide;
    logic [7:0] v;
    wmask(8'h88);
    pulse(4'b0001);
    @(negedge clk) begin stat_rd = 1'b1; evt_pulse = 4'b1000; end
    @(negedge clk) begin stat_rd = 1'b0; evt_pulse = '0; end
    chk("R9 read excludes coincident pulse", rd_data, 8'h01);
    chk("R9 coincident enabled pulse asserts irq_n", {7'b0, irq_n}, 8'h00);
    rdstat(v);
    chk("R9 coincident pulse kept", v, 8'h88);
  endtask

  task automatic t_flag;
    logic [7:0] v;
    wmask(8'h90);
    @(negedge clk) flag_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 not yet after two edges", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    chk("R10 flag fall asserts irq_n on third edge", {7'b0, irq_n}, 8'h00);
    rdstat(v);
    chk("R10 flag bit", v, 8'h90);
    repeat (6) @(negedge clk);
    rdstat(v);
    chk("R10 steady low counts once", v, 8'h00);
    @(negedge clk) flag_n = 1'b1;
    repeat (6) @(negedge clk);
    rdstat(v);
    chk("R10 rising edge ignored", v, 8'h00);
  endtask

  task automatic t_all;
    logic [7:0] v;
    @(negedge clk) flag_n = 1'b0;
    repeat (6) @(negedge clk);
    pulse(4'hF);
    rdstat(v);
    chk("R12 all sources, padding zero", v, 8'h9F);
    @(negedge clk) flag_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; evt_pulse = '0; flag_n = 1'b1;
    mask_wr = 1'b0; wr_data = '0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked_sources();
    t_enable_set();
    t_clear();
    t_late_enable();
    t_hold();
    t_coincide();
    t_flag();
    t_all();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule